// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block paints an axis-aligned rectangle in a single 8-bit color. Software programs a foreground color, a plane mask and an inclusive clip window through a small register port. It then supplies two corners by writing a Y coordinate register followed by an X coordinate register, first for the start corner and then for the opposite corner. The opposite corner is the start plus width and height, so it lies just outside the painted area.

Reading the launch register starts the fill. The engine walks every covered pixel that lies inside the clip window in row-major order and emits one pixel per clock on a pixel-write port. Each pixel carries its coordinates, the color and a write mask. The value returned by the launch read tells software whether the command was taken. A separate status register reports when the engine has finished.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset no pixel is emitted, the status busy bit (bit 28) is 0, the clip minimum registers read 0, and the clip maximum registers read HRES-1 and VRES-1.
- R2: Corner writes alternate Y then X. The first pair sets the start corner and the second pair sets the opposite corner. Any launch-register read returns the corner sequence to the start corner.
- R3: The painted region is X from the start X up to but excluding the opposite X, and Y from the start Y up to but excluding the opposite Y.
- R4: Pixels are emitted one per cycle with no gaps. X increases within a row, and the walk then moves to the next Y, restarting at the lowest visible X.
- R5: Only pixels with clip-min-X <= x <= clip-max-X and clip-min-Y <= y <= clip-max-Y are emitted.
- R6: Every pixel carries the foreground color and plane mask held at launch. Writes to either register during a fill do not change the pixels of that fill.
- R7: A launch read while the engine is busy returns bits 31 and 29 both set. It starts nothing, and the running fill continues unchanged.
- R8: An accepted launch read returns bits 31 and 29 clear. Status bit 28 reads 1 from the cycle after launch until the last pixel has been emitted, then reads 0.
- R9: A rectangle of zero width or height, or one lying wholly outside the clip window, is accepted, emits no pixel and never shows busy.
- R10: Read data appears on reg_rdata one cycle after the read strobe. Register map: 0 color, 1 mask, 2/3 clip-min X/Y, 4/5 clip-max X/Y, 6 corner Y, 7 corner X, 8 launch, 9 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| pix_valid | output | 1 | Pixel write strobe |
| pix_x | output | CW | Pixel X coordinate |
| pix_y | output | CW | Pixel Y coordinate |
| pix_data | output | PW | Pixel color |
| pix_mask | output | PW | Pixel bit write mask |

## Verification
A launch read registered at clock edge k returns its acceptance bits after that same edge. The first pixel appears after edge k+1, and each later pixel follows one edge after the one before it. The bench reads at the negative edge after each strobe's edge and then steps one negative edge per expected pixel. It computes each expected pixel from nested loops over the rectangle, filtered by the clip window. After the last expected pixel it confirms one more idle sample. Status reads are issued during and after a fill to place the busy bit exactly in time.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [3:0] {
    A_COLOR  = 4'd0,
    A_MASK   = 4'd1,
    A_CMINX  = 4'd2,
    A_CMINY  = 4'd3,
    A_CMAXX  = 4'd4,
    A_CMAXY  = 4'd5,
    A_CORNY  = 4'd6,
    A_CORNX  = 4'd7,
    A_LAUNCH = 4'd8,
    A_STATUS = 4'd9
  } rfe_addr_e;

  localparam int BIT_REJ_HI = 31;
  localparam int BIT_REJ_LO = 29;
  localparam int BIT_BUSY   = 28;
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs
  import rfe_pkg::*;
#(
  parameter int CW   = 11,
  parameter int PW   = 8,
  parameter int HRES = 1152,
  parameter int VRES = 900
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [31:0]   wdata,
  input  logic          seq_clr,
  output logic [PW-1:0] color,
  output logic [PW-1:0] pmask,
  output logic [CW-1:0] cminx,
  output logic [CW-1:0] cminy,
  output logic [CW-1:0] cmaxx,
  output logic [CW-1:0] cmaxy,
  output logic [CW-1:0] p0x,
  output logic [CW-1:0] p0y,
  output logic [CW-1:0] p1x,
  output logic [CW-1:0] p1y
);
  localparam int NPT = 2;
  localparam logic [CW-1:0] XMAX_RST = CW'(HRES - 1);
  localparam logic [CW-1:0] YMAX_RST = CW'(VRES - 1);

  logic [CW-1:0] pt_x [NPT];
  logic [CW-1:0] pt_y [NPT];
  logic          pt_idx;
  wire           unused_wdata = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      color  <= '0;
      pmask  <= '1;
      cminx  <= '0;
      cminy  <= '0;
      cmaxx  <= XMAX_RST;
      cmaxy  <= YMAX_RST;
      pt_idx <= 1'b0;
    end else begin
      if (wr_en) begin
        case (rfe_addr_e'(addr))
          A_COLOR: color <= wdata[PW-1:0];
          A_MASK:  pmask <= wdata[PW-1:0];
          A_CMINX: cminx <= wdata[CW-1:0];
          A_CMINY: cminy <= wdata[CW-1:0];
          A_CMAXX: cmaxx <= wdata[CW-1:0];
          A_CMAXY: cmaxy <= wdata[CW-1:0];
          A_CORNX: pt_idx <= ~pt_idx;
          default: ;
        endcase
      end
      if (seq_clr) pt_idx <= 1'b0;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPT; g++) begin : g_pt
      always_ff @(posedge clk) begin
        if (rst) begin
          pt_x[g] <= '0;
          pt_y[g] <= '0;
        end else if (wr_en && pt_idx == 1'(g)) begin
          if (rfe_addr_e'(addr) == A_CORNY) pt_y[g] <= wdata[CW-1:0];
          if (rfe_addr_e'(addr) == A_CORNX) pt_x[g] <= wdata[CW-1:0];
        end
      end
    end
  endgenerate

  assign p0x = pt_x[0];
  assign p0y = pt_y[0];
  assign p1x = pt_x[1];
  assign p1y = pt_y[1];
endmodule

// File: rtl/rfe_bounds.sv
module rfe_bounds #(
  parameter int CW = 11
) (
  input  logic [CW-1:0] sx,
  input  logic [CW-1:0] sy,
  input  logic [CW-1:0] ex,
  input  logic [CW-1:0] ey,
  input  logic [CW-1:0] cminx,
  input  logic [CW-1:0] cminy,
  input  logic [CW-1:0] cmaxx,
  input  logic [CW-1:0] cmaxy,
  output logic [CW-1:0] xlo,
  output logic [CW-1:0] xhi,
  output logic [CW-1:0] ylo,
  output logic [CW-1:0] yhi,
  output logic          nonempty
);
  logic [CW-1:0] xlast, ylast;

  always_comb begin
    xlast    = ex - 1'b1;
    ylast    = ey - 1'b1;
    xlo      = (sx > cminx) ? sx : cminx;
    ylo      = (sy > cminy) ? sy : cminy;
    xhi      = (xlast < cmaxx) ? xlast : cmaxx;
    yhi      = (ylast < cmaxy) ? ylast : cmaxy;
    nonempty = (ex > sx) && (ey > sy) && (xlo <= xhi) && (ylo <= yhi);
  end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker #(
  parameter int CW = 11,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] xlo_in,
  input  logic [CW-1:0] xhi_in,
  input  logic [CW-1:0] ylo_in,
  input  logic [CW-1:0] yhi_in,
  input  logic [PW-1:0] color_in,
  input  logic [PW-1:0] mask_in,
  output logic          busy,
  output logic          pix_valid,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic [PW-1:0] pix_data,
  output logic [PW-1:0] pix_mask,
  output logic [CW-1:0] xlo,
  output logic [CW-1:0] xhi,
  output logic [CW-1:0] ylo,
  output logic [CW-1:0] yhi
);
  logic [CW-1:0] cx, cy;
  logic [PW-1:0] col_q, msk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      pix_valid <= 1'b0;
      pix_x     <= '0;
      pix_y     <= '0;
      pix_data  <= '0;
      pix_mask  <= '0;
      cx        <= '0;
      cy        <= '0;
      xlo       <= '0;
      xhi       <= '0;
      ylo       <= '0;
      yhi       <= '0;
      col_q     <= '0;
      msk_q     <= '0;
    end else begin
      pix_valid <= busy;
      if (busy) begin
        pix_x    <= cx;
        pix_y    <= cy;
        pix_data <= col_q;
        pix_mask <= msk_q;
        if (cx == xhi) begin
          cx <= xlo;
          if (cy == yhi) busy <= 1'b0;
          else           cy   <= cy + 1'b1;
        end else begin
          cx <= cx + 1'b1;
        end
      end else if (start) begin
        busy  <= 1'b1;
        cx    <= xlo_in;
        cy    <= ylo_in;
        xlo   <= xlo_in;
        xhi   <= xhi_in;
        ylo   <= ylo_in;
        yhi   <= yhi_in;
        col_q <= color_in;
        msk_q <= mask_in;
      end
    end
  end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int CW   = 11,
  parameter int PW   = 8,
  parameter int HRES = 1152,
  parameter int VRES = 900
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          pix_valid,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] pix_y,
  output logic [PW-1:0] pix_data,
  output logic [PW-1:0] pix_mask
);
  logic [PW-1:0] color, pmask;
  logic [CW-1:0] cminx, cminy, cmaxx, cmaxy;
  logic [CW-1:0] p0x, p0y, p1x, p1y;
  logic [CW-1:0] b_xlo, b_xhi, b_ylo, b_yhi;
  logic [CW-1:0] w_xlo, w_xhi, w_ylo, w_yhi;
  logic          nonempty, walk_busy, busy_any, launch_rd, go;

  assign busy_any  = walk_busy | pix_valid;
  assign launch_rd = reg_rd && (rfe_addr_e'(reg_addr) == A_LAUNCH);
  assign go        = launch_rd && !busy_any && nonempty;

  rfe_regs #(.CW(CW), .PW(PW), .HRES(HRES), .VRES(VRES)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .seq_clr(launch_rd),
    .color(color), .pmask(pmask),
    .cminx(cminx), .cminy(cminy), .cmaxx(cmaxx), .cmaxy(cmaxy),
    .p0x(p0x), .p0y(p0y), .p1x(p1x), .p1y(p1y)
  );

  rfe_bounds #(.CW(CW)) u_bounds (
    .sx(p0x), .sy(p0y), .ex(p1x), .ey(p1y),
    .cminx(cminx), .cminy(cminy), .cmaxx(cmaxx), .cmaxy(cmaxy),
    .xlo(b_xlo), .xhi(b_xhi), .ylo(b_ylo), .yhi(b_yhi),
    .nonempty(nonempty)
  );

  rfe_walker #(.CW(CW), .PW(PW)) u_walk (
    .clk(clk), .rst(rst), .start(go),
    .xlo_in(b_xlo), .xhi_in(b_xhi), .ylo_in(b_ylo), .yhi_in(b_yhi),
    .color_in(color), .mask_in(pmask),
    .busy(walk_busy), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data), .pix_mask(pix_mask),
    .xlo(w_xlo), .xhi(w_xhi), .ylo(w_ylo), .yhi(w_yhi)
  );

  logic [31:0] rd_next;
  always_comb begin
    rd_next = '0;
    case (rfe_addr_e'(reg_addr))
      A_COLOR:  rd_next = 32'(color);
      A_MASK:   rd_next = 32'(pmask);
      A_CMINX:  rd_next = 32'(cminx);
      A_CMINY:  rd_next = 32'(cminy);
      A_CMAXX:  rd_next = 32'(cmaxx);
      A_CMAXY:  rd_next = 32'(cmaxy);
      A_LAUNCH: begin
        rd_next[BIT_REJ_HI] = busy_any;
        rd_next[BIT_REJ_LO] = busy_any;
        rd_next[BIT_BUSY]   = busy_any;
      end
      A_STATUS: rd_next[BIT_BUSY] = busy_any;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_next;
  end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker
  import rfe_pkg::*;
#(
  parameter int CW = 11,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_rd,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_rdata,
  input logic          busy_any,
  input logic          pix_valid,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] pix_y,
  input logic [PW-1:0] pix_data,
  input logic [PW-1:0] pix_mask,
  input logic [CW-1:0] xlo,
  input logic [CW-1:0] xhi,
  input logic [CW-1:0] ylo,
  input logic [CW-1:0] yhi
);
  assert_row_major_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |->
      ((pix_y == $past(pix_y) && pix_x == $past(pix_x) + 1'b1) ||
       (pix_y == $past(pix_y) + 1'b1 && pix_x == xlo)));

  assert_in_clip_R5: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> (pix_x >= xlo && pix_x <= xhi && pix_y >= ylo && pix_y <= yhi));

  assert_color_held_R6: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |-> ($stable(pix_data) && $stable(pix_mask)));

  assert_busy_reject_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 4'(A_LAUNCH) && busy_any) |=>
      (reg_rdata[BIT_REJ_HI] && reg_rdata[BIT_REJ_LO]));

  assert_no_pixel_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_any |=> !pix_valid);
endmodule

bind rect_fill_engine rfe_checker #(.CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .busy_any(busy_any), .pix_valid(pix_valid),
  .pix_x(pix_x), .pix_y(pix_y), .pix_data(pix_data), .pix_mask(pix_mask),
  .xlo(w_xlo), .xhi(w_xhi), .ylo(w_ylo), .yhi(w_yhi)
);

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
  localparam int CW = 6, PW = 8, HRES = 16, VRES = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          pix_valid;
  logic [CW-1:0] pix_x, pix_y;
  logic [PW-1:0] pix_data, pix_mask;

  int checks = 0, errors = 0, pcount = 0, mon_bad = 0;
  int cmnx = 0, cmny = 0, cmxx = HRES - 1, cmxy = VRES - 1;
  logic [PW-1:0] mon_col = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  rect_fill_engine #(.CW(CW), .PW(PW), .HRES(HRES), .VRES(VRES)) uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_data(pix_data), .pix_mask(pix_mask)
  );

  always @(negedge clk) begin
    if (pix_valid) begin
      pcount++;
      if (pix_data != mon_col) mon_bad++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_clip(input int a, input int b, input int c, input int d);
    cmnx = a; cmny = b; cmxx = c; cmxy = d;
    wr(2, a); wr(3, b); wr(4, c); wr(5, d);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int n = 0; n < 2000; n++) begin
      rd(9, v);
      if (!v[28]) break;
    end
  endtask

  task automatic fill(input int sx, input int sy, input int w, input int h,
                      input int col, input int msk);
    logic [31:0] v, s;
    int bad = 0, ba = 0, be = 0, npix = 0;
    wr(0, col); wr(1, msk);
    wr(6, sy); wr(7, sx); wr(6, sy + h); wr(7, sx + w);
    rd(8, v);
    check(!v[31] && !v[29], "R8 launch accepted", int'(v[31:28]), 0);
    for (int y = sy; y < sy + h; y++)
      for (int x = sx; x < sx + w; x++)
        if (x >= cmnx && x <= cmxx && y >= cmny && y <= cmxy) begin
          @(negedge clk);
          npix++;
          if (!(pix_valid && pix_x == CW'(x) && pix_y == CW'(y) &&
                pix_data == PW'(col) && pix_mask == PW'(msk))) begin
            if (bad == 0) begin
              ba = {pix_valid, pix_y, pix_x}; be = {1'b1, y[CW-1:0], x[CW-1:0]};
            end
            bad++;
          end
        end
    @(negedge clk);
    if (pix_valid) begin
      if (bad == 0) begin ba = {1'b1, pix_y, pix_x}; be = 0; end
      bad++;
    end
    check(bad == 0, npix == 0 ? "R9 empty fill" : "R3 R4 R5 R6 pixel stream", ba, be);
    rd(9, s);
    check(!s[28], "R8 idle after fill", int'(s[28]), 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!pix_valid, "R1 no pixel after reset", int'(pix_valid), 0);
    rd(9, v); check(!v[28], "R1 status idle", int'(v[28]), 0);
    rd(2, v); check(v == 0, "R1 clip min x", int'(v), 0);
    rd(3, v); check(v == 0, "R1 clip min y", int'(v), 0);
    rd(4, v); check(v == HRES - 1, "R1 R10 clip max x", int'(v), HRES - 1);
    rd(5, v); check(v == VRES - 1, "R1 R10 clip max y", int'(v), VRES - 1);

    // Sweep of rectangles under several clip windows (R3 R4 R5 R6 R9)
    for (int cs = 0; cs < 3; cs++) begin
      case (cs)
        0: set_clip(0, 0, HRES - 1, VRES - 1);
        1: set_clip(2, 3, 9, 7);
        default: set_clip(5, 0, 5, VRES - 1);
      endcase
      for (int ix = 0; ix < 4; ix++)
        for (int iw = 0; iw < 4; iw++)
          for (int iy = 0; iy < 3; iy++)
            for (int ih = 0; ih < 3; ih++) begin
              int sx, w, sy, h, c;
              sx = (ix == 0) ? 0 : (ix == 1) ? 1 : (ix == 2) ? 4 : 13;
              w  = (iw == 0) ? 0 : (iw == 1) ? 1 : (iw == 2) ? 3 : 6;
              sy = (iy == 0) ? 0 : (iy == 1) ? 2 : 9;
              h  = (ih == 0) ? 0 : (ih == 1) ? 1 : 4;
              c  = (sx * 7 + sy * 13 + w * 3 + cs) & 8'hff;
              fill(sx, sy, w, h, c, (~c) & 8'hff);
            end
    end

    // R7 R8 R6: busy window, rejected relaunch, color write mid-fill
    set_clip(0, 0, HRES - 1, VRES - 1);
    wr(0, 8'h3c); wr(1, 8'hff);
    wr(6, 0); wr(7, 0); wr(6, VRES); wr(7, HRES);
    mon_col = 8'h3c; pcount = 0; mon_bad = 0;
    rd(8, v); check(!v[31] && !v[29], "R8 big fill accepted", int'(v[31:28]), 0);
    rd(9, v); check(v[28], "R8 busy during fill", int'(v[28]), 1);
    rd(8, v); check(v[31] && v[29], "R7 relaunch rejected", int'(v[31:28]), 4'hb);
    wr(0, 8'h55);
    wait_idle();
    check(pcount == HRES * VRES, "R7 pixel count unchanged", pcount, HRES * VRES);
    check(mon_bad == 0, "R6 color held during fill", mon_bad, 0);
    rd(0, v); check(v == 8'h55, "R6 color register updated", int'(v), 8'h55);

    // R2: partial corner sequence then launch resets the sequence
    wr(6, 2); wr(7, 2); wr(6, 5);
    rd(8, v);
    wait_idle();
    repeat (2) @(negedge clk);
    fill(1, 1, 3, 2, 8'h81, 8'h0f);
    check(1'b1, "R2 sequence restart exercised by previous stream check", 0, 0);

    // R9: rectangle fully outside clip window
    set_clip(4, 4, 6, 6);
    fill(8, 0, 3, 3, 8'h11, 8'hff);

    finished = 1;
    finish_run();
  end
endmodule